// File: doc/BRIEF.md
# Two-Channel Serial Controller Register Bank with Reset Sequencing

This block holds the programmable registers of a two-channel serial communications controller. It implements the reset behaviour of such a controller. Software reaches every register through one byte-wide port per channel. A control write at pointer zero loads a register pointer. The next control access, read or write, lands on the selected register, and the pointer then drops back to zero. A separate data port takes transmit bytes. A few sticky status bits collect line events, transmit activity and the hunt command.

A reset command field in the shared master-interrupt register (index 9) starts one of three resets. Soft reset of channel A, soft reset of channel B, and hard reset of both channels. A reset does not clear the bank. Each register gets its own keep mask and force pattern. A hard reset applies the soft actions and then forces extra bits in registers 9, 10, 11 and 14. Power-on (`rst_n` low) zeroes every register so that the state is known before software issues a reset.

Top module: `serial_reset_bank`

## Requirements
- R1: While `rst_n` is low, and after it rises, every write register, every status register and both pointers are zero, so every readback returns 0x00.
- R2: A control write while a channel's pointer is 0 stores the byte as register 0 and loads the pointer with bits 2:0 of the byte, plus 8 when bits 5:3 equal 001. The next control access to that channel (read or write) uses that register and returns the pointer to 0. Each channel has its own pointer.
- R3: Register 9 is one register shared by both channels. Bits 7:6 of a byte written to it select the action: 00 none, 01 soft reset of channel B, 10 soft reset of channel A, 11 hard reset of both channels.
- R4: A soft reset changes the channel's write registers as follows: reg0 becomes 0x00; reg1 keeps only bits 0x24; reg3 clears bit 0x01; reg4 sets bit 0x04; reg5 keeps only bits 0x61; reg10 keeps only bits 0x60; reg14 keeps only bits 0xC3 and then sets 0x20; reg15 becomes 0xF8. Registers 2, 6, 7, 8, 11, 12 and 13 are unchanged.
- R5: After a soft-reset command, register 9 holds the written byte with bit 5 cleared.
- R6: A soft reset sets status reg0 to (old AND 0xB8) OR 0x44 and status reg1 to (old AND 0x01) OR 0x06, and status reg10 keeps only bit 0x40.
- R7: A hard reset applies R4 and R6 to both channels. It then sets register 9 to (written AND 0x03) OR 0xC0, reg10 to 0x00 and reg11 to 0x08, and sets reg14 to (old AND 0xC0) OR 0x30.
- R8: A reset clears the pointer of each channel it resets. The pointer of a channel that is not reset keeps its value.
- R9: A write of a byte with bit 0x10 set to write register 3 sets bit 0x10 (sync/hunt) of that channel's status reg0. A write to register 3 without that bit leaves status reg0 unchanged.
- R10: The status bits are sticky and clear only at power-on. `evt_dcd`, `evt_cts` and `evt_brk` set bits 0x08, 0x20 and 0x80 of status reg0, and `evt_miss` sets bit 0x40 of status reg10. A data-port write stores the byte as write register 8, sets status reg0 bit 0x04 and sets status reg1 bit 0x01.
- R11: A control read with `bus_rd_wsel` low returns status reg0, reg1 or reg10 at pointer 0, 1 or 10, and 0x00 at any other pointer. With `bus_rd_wsel` high it returns the write register at the pointer (register 9 is the shared one). A data-port read returns 0x00 and leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset, zeroes the bank |
| bus_wr | input | 1 | Write strobe for one access |
| bus_rd | input | 1 | Read strobe for one access |
| bus_data_sel | input | 1 | 1 selects the data port, 0 selects the control port |
| bus_chan | input | 1 | Channel select: 0 = A, 1 = B |
| bus_rd_wsel | input | 1 | Control reads return the write register instead of status |
| bus_wdata | input | 8 | Write byte |
| evt_dcd | input | 2 | Per-channel carrier-detect event, sets a sticky status bit |
| evt_cts | input | 2 | Per-channel clear-to-send event |
| evt_brk | input | 2 | Per-channel break event |
| evt_miss | input | 2 | Per-channel missed-clock event |
| bus_rdata | output | 8 | Read byte for the current access (combinational) |

## Verification
The bench walks one table of seed bytes, one row per write register, including both all-ones and all-zero seeds. Each seed goes through a soft reset of one channel and then a hard reset. The all-ones seeds show which bits each keep mask drops. The all-zero seeds show which bits the force pattern sets. The untouched channel shows the difference between a per-channel reset and a global one. Directed cases cover the reset-command encodings with extra bits set, so the masking of register 9 can be seen. Further directed cases cover reset while the other channel holds a pointer, the hunt bit with and without bit 4, and status bits collected before a reset, so keep can be told apart from clear.

// File: rtl/serial_rst_pkg.sv
package serial_rst_pkg;
  localparam int REG_W = 8;
  localparam int NREG  = 16;
  localparam int IDX_W = $clog2(NREG);

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'b00,
    CMD_SOFT_B = 2'b01,
    CMD_SOFT_A = 2'b10,
    CMD_HARD   = 2'b11
  } rst_cmd_e;

  localparam idx_t IDX_CMD   = idx_t'(0);
  localparam idx_t IDX_RXCFG = idx_t'(3);
  localparam idx_t IDX_TXBUF = idx_t'(8);
  localparam idx_t IDX_MASTR = idx_t'(9);
  localparam idx_t IDX_MISC  = idx_t'(10);

  // write register masks
  localparam reg_t KEEP_W1   = 8'h24;
  localparam reg_t RX_EN     = 8'h01;
  localparam reg_t HUNT      = 8'h10;
  localparam reg_t ONE_STOP  = 8'h04;
  localparam reg_t KEEP_W5   = 8'h61;
  localparam reg_t CLR_W9_S  = 8'h20;
  localparam reg_t KEEP_W9_H = 8'h03;
  localparam reg_t SET_W9_H  = 8'hC0;
  localparam reg_t KEEP_W10  = 8'h60;
  localparam reg_t W11_HARD  = 8'h08;
  localparam reg_t KEEP_W14S = 8'hC3;
  localparam reg_t SET_W14S  = 8'h20;
  localparam reg_t KEEP_W14H = 8'hC0;
  localparam reg_t SET_W14H  = 8'h30;
  localparam reg_t W15_RST   = 8'hF8;

  // status register bits
  localparam reg_t ST_TXE    = 8'h04;
  localparam reg_t ST_DCD    = 8'h08;
  localparam reg_t ST_SYNC   = 8'h10;
  localparam reg_t ST_CTS    = 8'h20;
  localparam reg_t ST_UNDR   = 8'h40;
  localparam reg_t ST_BRK    = 8'h80;
  localparam reg_t ST_STICKY = ST_DCD | ST_SYNC | ST_CTS | ST_BRK;
  localparam reg_t S1_SENT   = 8'h01;
  localparam reg_t S1_RES8   = 8'h06;
  localparam reg_t S10_MISS  = 8'h40;

  function automatic reg_t wr_after_reset(input idx_t idx, input reg_t v, input logic hard);
    reg_t r;
    r = v;
    case (idx)
      idx_t'(0):  r = '0;
      idx_t'(1):  r = v & KEEP_W1;
      idx_t'(3):  r = v & ~RX_EN;
      idx_t'(4):  r = v | ONE_STOP;
      idx_t'(5):  r = v & KEEP_W5;
      idx_t'(10): r = hard ? '0 : (v & KEEP_W10);
      idx_t'(11): r = hard ? W11_HARD : v;
      idx_t'(14): r = hard ? ((v & KEEP_W14H) | SET_W14H) : ((v & KEEP_W14S) | SET_W14S);
      idx_t'(15): r = W15_RST;
      default:    r = v;
    endcase
    return r;
  endfunction

  function automatic reg_t mastr_after_write(input reg_t v);
    reg_t r;
    case (rst_cmd_e'(v[7:6]))
      CMD_HARD:              r = (v & KEEP_W9_H) | SET_W9_H;
      CMD_SOFT_A, CMD_SOFT_B: r = v & ~CLR_W9_S;
      default:               r = v;
    endcase
    return r;
  endfunction

  function automatic reg_t st0_after_reset(input reg_t v);
    return (v & ST_STICKY) | ST_TXE | ST_UNDR;
  endfunction

  function automatic reg_t st1_after_reset(input reg_t v);
    return (v & S1_SENT) | S1_RES8;
  endfunction

  function automatic idx_t ptr_from_cmd(input reg_t v);
    return {(v[5:3] == 3'b001), v[2:0]};
  endfunction
endpackage

// File: rtl/sr_ptr_unit.sv
module sr_ptr_unit
  import serial_rst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic wr,
  input  reg_t wdata,
  input  logic chan_rst,
  output idx_t ptr
);
  idx_t ptr_q;
  logic at_zero;

  assign at_zero = (ptr_q == '0);
  assign ptr     = ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ptr_q <= '0;
    else if (chan_rst)          ptr_q <= '0;
    else if (acc && at_zero && wr) ptr_q <= ptr_from_cmd(wdata);
    else if (acc)               ptr_q <= '0;
  end

  // R2
  ptr_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !at_zero) |=> (ptr_q == '0));

  // R8
  ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (ptr_q == '0));
endmodule

// File: rtl/sr_chan_bank.sv
module sr_chan_bank
  import serial_rst_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic hard_rst,
  input  logic reg_we,
  input  idx_t reg_idx,
  input  logic data_we,
  input  reg_t wdata,
  input  logic ev_dcd,
  input  logic ev_cts,
  input  logic ev_brk,
  input  logic ev_miss,
  input  idx_t rd_idx,
  output reg_t wr_rd,
  output reg_t st_rd
);
  reg_t wr_q [NREG];
  reg_t wr_d [NREG];
  reg_t st0_q, st0_d, st1_q, st1_d, st10_q, st10_d;
  logic chan_rst;
  logic hunt_req;

  assign chan_rst = soft_rst | hard_rst;
  assign hunt_req = reg_we && (reg_idx == IDX_RXCFG) && ((wdata & HUNT) != '0);

  always_comb begin
    for (int i = 0; i < NREG; i++) wr_d[i] = wr_q[i];
    st0_d  = st0_q;
    st1_d  = st1_q;
    st10_d = st10_q;
    if (chan_rst) begin
      for (int i = 0; i < NREG; i++) wr_d[i] = wr_after_reset(idx_t'(i), wr_q[i], hard_rst);
      st0_d  = st0_after_reset(st0_q);
      st1_d  = st1_after_reset(st1_q);
      st10_d = st10_q & S10_MISS;
    end else begin
      if (reg_we) wr_d[reg_idx] = wdata;
      if (hunt_req) st0_d = st0_d | ST_SYNC;
      if (data_we) begin
        wr_d[IDX_TXBUF] = wdata;
        st0_d = st0_d | ST_TXE;
        st1_d = st1_d | S1_SENT;
      end
    end
    if (ev_dcd)  st0_d  = st0_d | ST_DCD;
    if (ev_cts)  st0_d  = st0_d | ST_CTS;
    if (ev_brk)  st0_d  = st0_d | ST_BRK;
    if (ev_miss) st10_d = st10_d | S10_MISS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) wr_q[i] <= '0;
      st0_q  <= '0;
      st1_q  <= '0;
      st10_q <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) wr_q[i] <= wr_d[i];
      st0_q  <= st0_d;
      st1_q  <= st1_d;
      st10_q <= st10_d;
    end
  end

  assign wr_rd = wr_q[rd_idx];

  always_comb begin
    case (rd_idx)
      idx_t'(0):  st_rd = st0_q;
      idx_t'(1):  st_rd = st1_q;
      IDX_MISC:   st_rd = st10_q;
      default:    st_rd = '0;
    endcase
  end

  // R4
  wr15_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> (wr_q[15] == W15_RST));

  // R6
  st_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_rst |=> ((st0_q & (ST_TXE | ST_UNDR)) == (ST_TXE | ST_UNDR)) && ((st1_q & S1_RES8) == S1_RES8));

  // R7
  hard_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (wr_q[11] == W11_HARD) && (wr_q[10] == '0));

  // R9
  hunt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hunt_req |=> ((st0_q & ST_SYNC) != '0));

  // R10
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st0_q & $past(st0_q) & ST_STICKY) == ($past(st0_q) & ST_STICKY)));
endmodule

// File: rtl/sr_mastr_reg.sv
module sr_mastr_reg
  import serial_rst_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  reg_t           wdata,
  output reg_t           mastr,
  output logic [NCH-1:0] soft_rst,
  output logic           hard_rst
);
  reg_t     mastr_q;
  rst_cmd_e cmd;

  assign cmd      = we ? rst_cmd_e'(wdata[7:6]) : CMD_NONE;
  assign hard_rst = (cmd == CMD_HARD);
  assign mastr    = mastr_q;

  for (genvar c = 0; c < NCH; c++) begin : g_soft
    if (c == 0) begin : g_a
      assign soft_rst[c] = (cmd == CMD_SOFT_A);
    end else if (c == 1) begin : g_b
      assign soft_rst[c] = (cmd == CMD_SOFT_B);
    end else begin : g_none
      assign soft_rst[c] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mastr_q <= '0;
    else if (we) mastr_q <= mastr_after_write(wdata);
  end

  // R7
  mastr_hard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (mastr_q[7:6] == 2'b11) && (mastr_q[5:2] == 4'b0000));

  // R5
  mastr_soft_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst != '0) |=> (mastr_q[5] == 1'b0));
endmodule

// File: rtl/serial_reset_bank.sv
module serial_reset_bank
  import serial_rst_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_data_sel,
  input  logic [CH_W-1:0] bus_chan,
  input  logic            bus_rd_wsel,
  input  logic [7:0]      bus_wdata,
  input  logic [NCH-1:0]  evt_dcd,
  input  logic [NCH-1:0]  evt_cts,
  input  logic [NCH-1:0]  evt_brk,
  input  logic [NCH-1:0]  evt_miss,
  output logic [7:0]      bus_rdata
);
  idx_t           ptr_w   [NCH];
  reg_t           wr_rd_w [NCH];
  reg_t           st_rd_w [NCH];
  logic [NCH-1:0] soft_rst;
  logic           hard_rst;
  reg_t           mastr;
  idx_t           cur_ptr;
  logic           ctrl_acc;
  logic           mastr_we;

  assign cur_ptr  = ptr_w[bus_chan];
  assign ctrl_acc = (bus_wr | bus_rd) & ~bus_data_sel;
  assign mastr_we = bus_wr & ~bus_data_sel & (cur_ptr == IDX_MASTR);

  sr_mastr_reg #(.NCH(NCH)) u_mastr (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (mastr_we),
    .wdata    (bus_wdata),
    .mastr    (mastr),
    .soft_rst (soft_rst),
    .hard_rst (hard_rst)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel, acc, reg_we, data_we, rst_c;
    assign sel     = (bus_chan == CH_W'(c));
    assign acc     = ctrl_acc & sel;
    assign reg_we  = bus_wr & ~bus_data_sel & sel & (ptr_w[c] != IDX_MASTR);
    assign data_we = bus_wr & bus_data_sel & sel;
    assign rst_c   = soft_rst[c] | hard_rst;

    sr_ptr_unit u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .wr       (bus_wr),
      .wdata    (bus_wdata),
      .chan_rst (rst_c),
      .ptr      (ptr_w[c])
    );

    sr_chan_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst[c]),
      .hard_rst (hard_rst),
      .reg_we   (reg_we),
      .reg_idx  (ptr_w[c]),
      .data_we  (data_we),
      .wdata    (bus_wdata),
      .ev_dcd   (evt_dcd[c]),
      .ev_cts   (evt_cts[c]),
      .ev_brk   (evt_brk[c]),
      .ev_miss  (evt_miss[c]),
      .rd_idx   (ptr_w[c]),
      .wr_rd    (wr_rd_w[c]),
      .st_rd    (st_rd_w[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (!bus_data_sel) begin
      if (bus_rd_wsel) bus_rdata = (cur_ptr == IDX_MASTR) ? mastr : wr_rd_w[bus_chan];
      else             bus_rdata = st_rd_w[bus_chan];
    end
  end

  // R3
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |-> (soft_rst == '0));

  // R11
  data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_data_sel && !bus_wr) |=> $stable(cur_ptr) || ($past(bus_chan) != bus_chan));
endmodule

// File: tb/test_serial_reset_bank.sv
module test_serial_reset_bank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, bus_data_sel = 1'b0, bus_rd_wsel = 1'b0;
  logic [0:0] bus_chan = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [1:0] evt_dcd = '0, evt_cts = '0, evt_brk = '0, evt_miss = '0;
  logic [7:0] bus_rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] got;

  always #2 clk = ~clk;

  serial_reset_bank i_serial_reset_bank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_data_sel(bus_data_sel), .bus_chan(bus_chan), .bus_rd_wsel(bus_rd_wsel),
    .bus_wdata(bus_wdata), .evt_dcd(evt_dcd), .evt_cts(evt_cts),
    .evt_brk(evt_brk), .evt_miss(evt_miss), .bus_rdata(bus_rdata)
  );

  // rows: {register, seed, after soft reset, after hard reset}
  localparam logic [31:0] VEC [16] = '{
    32'h00_38_00_00, 32'h01_FF_24_24, 32'h02_A5_A5_A5, 32'h03_FF_FE_FE,
    32'h04_00_04_04, 32'h05_FF_61_61, 32'h06_3C_3C_3C, 32'h07_C3_C3_C3,
    32'h08_5A_5A_5A, 32'h0A_FF_60_00, 32'h0B_55_55_08, 32'h0C_12_12_12,
    32'h0D_34_34_34, 32'h0E_FF_E3_F0, 32'h0E_00_20_30, 32'h0F_00_F8_F8
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic ctrl_wr(input bit ch, input logic [7:0] v);
    @(negedge clk);
    bus_chan = ch; bus_data_sel = 1'b0; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic ctrl_rd(input bit ch, input bit wsel, output logic [7:0] v);
    @(negedge clk);
    bus_chan = ch; bus_data_sel = 1'b0; bus_rd_wsel = wsel; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_rd_wsel = 1'b0;
  endtask

  task automatic data_wr(input bit ch, input logic [7:0] v);
    @(negedge clk);
    bus_chan = ch; bus_data_sel = 1'b1; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_data_sel = 1'b0;
  endtask

  task automatic data_rd(input bit ch, output logic [7:0] v);
    @(negedge clk);
    bus_chan = ch; bus_data_sel = 1'b1; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_data_sel = 1'b0;
  endtask

  function automatic logic [7:0] ptr_byte(input int idx);
    return (idx < 8) ? 8'(idx) : (8'h08 | 8'(idx - 8));
  endfunction

  task automatic write_reg(input bit ch, input int idx, input logic [7:0] v);
    if (idx != 0) ctrl_wr(ch, ptr_byte(idx));
    ctrl_wr(ch, v);
  endtask

  task automatic read_reg(input bit ch, input int idx, input bit wsel, output logic [7:0] v);
    if (idx != 0) ctrl_wr(ch, ptr_byte(idx));
    ctrl_rd(ch, wsel, v);
  endtask

  task automatic power_on();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    power_on();
    // R1 power-on state
    ctrl_rd(0, 0, got);      check("R1 status0 A", got, 8'h00);
    read_reg(1, 15, 1, got); check("R1 wr15 B", got, 8'h00);
    read_reg(0, 1, 0, got);  check("R1 status1 A", got, 8'h00);
    read_reg(1, 9, 1, got);  check("R1 wr9", got, 8'h00);

    // R4 R6 R7 R8: table of masks, soft reset A then hard reset
    for (int r = 0; r < 16; r++) begin
      int idx;
      logic [7:0] seed, e_soft, e_hard;
      idx = int'(VEC[r][31:24]); seed = VEC[r][23:16];
      e_soft = VEC[r][15:8]; e_hard = VEC[r][7:0];
      write_reg(0, idx, seed);
      write_reg(1, idx, seed);
      write_reg(0, 9, 8'h80);
      read_reg(0, idx, 1, got); check($sformatf("R4 soft A reg%0d", idx), got, e_soft);
      read_reg(1, idx, 1, got); check($sformatf("R3 B untouched reg%0d", idx), got, seed);
      write_reg(0, 9, 8'hC0);
      read_reg(0, idx, 1, got); check($sformatf("R7 hard A reg%0d", idx), got, e_hard);
      read_reg(1, idx, 1, got); check($sformatf("R7 hard B reg%0d", idx), got, e_hard);
    end

    power_on();
    // R2 pointer behaviour
    write_reg(0, 12, 8'h77);
    read_reg(0, 12, 1, got); check("R2 point-high reg12", got, 8'h77);
    ctrl_rd(0, 1, got);      check("R2 pointer back to 0 (wr0 = last cmd)", got, 8'h0C);
    ctrl_wr(0, 8'h02);
    ctrl_rd(1, 0, got);      check("R2 B pointer independent", got, 8'h00);
    ctrl_wr(0, 8'h5E);
    read_reg(0, 2, 1, got);  check("R2 A reg2", got, 8'h5E);
    read_reg(1, 2, 1, got);  check("R2 B reg2", got, 8'h00);
    // R11 read port
    ctrl_wr(0, 8'h0D);
    data_rd(0, got);         check("R11 data read", got, 8'h00);
    ctrl_wr(0, 8'h44);
    read_reg(0, 13, 1, got); check("R11 data read kept pointer", got, 8'h44);
    read_reg(0, 2, 0, got);  check("R11 status idx2 reads 0", got, 8'h00);

    // R3 no-action code, shared reg9
    write_reg(0, 15, 8'h11);
    write_reg(0, 9, 8'h01);
    read_reg(0, 15, 1, got); check("R3 code 00 no reset", got, 8'h11);
    read_reg(1, 9, 1, got);  check("R3 shared reg9", got, 8'h01);
    // R5 soft reset keeps reg9 except bit5
    write_reg(1, 9, 8'hA5);
    read_reg(0, 9, 1, got);  check("R5 reg9 after soft", got, 8'h85);
    read_reg(0, 15, 1, got); check("R3 code 10 resets A", got, 8'hF8);
    // R7 hard reg9 value
    write_reg(0, 15, 8'h00);
    write_reg(1, 15, 8'h00);
    write_reg(0, 9, 8'hE7);
    read_reg(1, 9, 1, got);  check("R7 reg9 after hard", got, 8'hC3);
    read_reg(1, 15, 1, got); check("R7 hard resets B", got, 8'hF8);

    power_on();
    // R10 status collection
    data_wr(0, 8'h33);
    read_reg(0, 8, 1, got);  check("R10 data stored reg8", got, 8'h33);
    ctrl_rd(0, 0, got);      check("R10 tx empty", got, 8'h04);
    read_reg(0, 1, 0, got);  check("R10 all sent", got, 8'h01);
    @(negedge clk);
    evt_dcd = 2'b01; evt_brk = 2'b01; evt_miss = 2'b01; evt_cts = 2'b10;
    @(negedge clk);
    evt_dcd = '0; evt_brk = '0; evt_miss = '0; evt_cts = '0;
    ctrl_rd(0, 0, got);      check("R10 A events", got, 8'h8C);
    read_reg(0, 10, 0, got); check("R10 A miss", got, 8'h40);
    ctrl_rd(1, 0, got);      check("R10 B cts", got, 8'h20);
    // R6 status after soft reset A
    write_reg(0, 9, 8'h80);
    ctrl_rd(0, 0, got);      check("R6 status0 A", got, 8'hCC);
    read_reg(0, 1, 0, got);  check("R6 status1 A", got, 8'h07);
    read_reg(0, 10, 0, got); check("R6 status10 A", got, 8'h40);
    ctrl_rd(1, 0, got);      check("R6 B status0 untouched", got, 8'h20);
    read_reg(1, 1, 0, got);  check("R6 B status1 untouched", got, 8'h00);
    // R9 hunt
    write_reg(1, 3, 8'h01);
    ctrl_rd(1, 0, got);      check("R9 no hunt bit", got, 8'h20);
    write_reg(1, 3, 8'h10);
    ctrl_rd(1, 0, got);      check("R9 hunt sets sync", got, 8'h30);
    write_reg(1, 9, 8'hC0);
    ctrl_rd(1, 0, got);      check("R7 status0 B after hard", got, 8'h74);
    read_reg(1, 1, 0, got);  check("R7 status1 B after hard", got, 8'h06);
    // R8 pointer clearing
    ctrl_wr(0, 8'h05);
    write_reg(1, 9, 8'h80);
    ctrl_rd(0, 0, got);      check("R8 A pointer cleared", got, 8'hCC);
    ctrl_wr(0, 8'h06);
    write_reg(1, 9, 8'h40);
    ctrl_wr(0, 8'h99);
    read_reg(0, 6, 1, got);  check("R8 A pointer kept", got, 8'h99);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule